// File: doc/BRIEF.md
# Key-Protected Watchdog Reset Timer

This block is the chip's hard-reset watchdog. It holds a down-counter and a two-bit enable field. Neither can be changed until the correct unlock value has been written to a key register. Software writes the unlock value first, then loads the count and sets the enables. While the count-enable bit is set, the counter drops by one on every clock. When it stands at zero with the reset-enable bit also set, the block drives a reset pulse of fixed length onto `wdg_rst_o`. A value of zero written to the count while both enables are set therefore gives a reset on the very next clock edge.

When the pulse is over, the block returns to its own reset state. The count goes back to its initial value, both enables are cleared and the key is locked. Any write to the key register with a value other than the unlock constant locks the block again.

Access is through a plain register port: one write strobe, a two-bit address, 32-bit write data and a combinational read mux. The port has no back-pressure, so a write presented with `reg_we` high is taken on that clock edge. The address map is: 0 key, 1 count, 2 enable, 3 reads as zero.

Top module: `wdg_timer`

## Requirements
- R1: A write of 32'h5AFE_C0DE to address 0 unlocks the block. A write of any other value to address 0 locks it. Reading address 0 returns 1 in bit 0 when the block is unlocked and 0 when it is locked. All other bits read 0.
- R2: A write to the count register (address 1) is taken only while the block is unlocked. A write while locked leaves the value read back from address 1 unchanged.
- R3: A write to the enable register (address 2) is taken only while the block is unlocked. A write while locked leaves the value read back from address 2 unchanged. Bit 0 of the enable register is count-enable and bit 1 is reset-enable.
- R4: While count-enable is set and the count is non-zero, the count drops by exactly one per clock. A count write on the same edge takes precedence over the decrement.
- R5: While count-enable is clear, the count holds its value and no reset is produced.
- R6: If the count is zero and both enable bits are set, `wdg_rst_o` rises on the next clock edge. A count of N written on edge k, with both enables already set, raises `wdg_rst_o` on edge k+N+1, so a write of zero raises it on edge k+1.
- R7: With reset-enable clear, the count stops at zero and no reset is produced. Setting reset-enable later raises `wdg_rst_o` on the edge after the enable write.
- R8: `wdg_rst_o` stays high for exactly PULSE_CYCLES (default 4) clocks. While it is high, register writes and counting are suspended. When it falls, the count is COUNT_INIT, the enable field is 0 and the block is locked.
- R9: After `rst_n` is released, `wdg_rst_o` is low, the block is locked, the enable field reads 0 and the count reads COUNT_INIT (default 32'hFFFF_FFFF).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe, taken on the rising edge |
| reg_addr | input | 2 | Register address (0 key, 1 count, 2 enable) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| wdg_rst_o | output | 1 | Hard-reset pulse, active high |

## Verification
The expiry path is driven with a sweep of loaded counts from 0 to 15, with both enables set. Measuring the cycles to the rising edge of `wdg_rst_o` tells a correct N+1 latency apart from a missing or doubled stage, or a counter that stops at one. Each sweep step also measures the pulse width and reads back the post-pulse state, which separates a reset that merely pulses from one that also relocks and clears the block.

A set of key values is written in turn: the exact constant, its neighbours one bit away, zero and all ones. Each is followed by writes to count and enable and a readback, which shows whether the lock gate and the relock on a wrong key work. Separate runs with only count-enable set, and with neither enable set, distinguish a stopped counter from one that decrements. They also show whether a counter sitting at zero without reset-enable wrongly fires.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_KEY = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CNT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_EN  = 2'd2;

  // Enable field: bit 1 reset-enable, bit 0 count-enable.
  typedef struct packed {
    logic rst_en;
    logic cnt_en;
  } wdg_en_t;

  localparam int unsigned EN_W = $bits(wdg_en_t);

endpackage

// File: rtl/wdg_key_lock.sv
module wdg_key_lock #(
  parameter int unsigned   KEY_W     = 32,
  parameter logic [KEY_W-1:0] KEY_VALUE = 32'h5AFE_C0DE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_key,
  input  logic [KEY_W-1:0] wdata,
  input  logic             clear,
  output logic             unlocked
);

  logic open_q;

  // Only the result of the comparison is kept, not the key itself.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
    end else if (clear) begin
      open_q <= 1'b0;
    end else if (wr_key) begin
      open_q <= (wdata == KEY_VALUE);
    end
  end

  assign unlocked = open_q;

endmodule

// File: rtl/wdg_counter.sv
module wdg_counter
  import wdg_pkg::*;
#(
  parameter int unsigned      CNT_W      = 32,
  parameter logic [CNT_W-1:0] COUNT_INIT = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_cnt,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  wdg_en_t          en_wdata,
  input  logic             freeze,
  input  logic             clear,
  output logic [CNT_W-1:0] count,
  output wdg_en_t          en,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;
  wdg_en_t          en_q;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= COUNT_INIT;
    end else if (clear) begin
      cnt_q <= COUNT_INIT;
    end else if (!freeze) begin
      if (wr_cnt) begin
        cnt_q <= cnt_wdata;
      end else if (en_q.cnt_en && !at_zero) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (clear) begin
      en_q <= '0;
    end else if (!freeze && wr_en) begin
      en_q <= en_wdata;
    end
  end

  assign expire = at_zero && en_q.cnt_en && en_q.rst_en && !freeze;
  assign count  = cnt_q;
  assign en     = en_q;

endmodule

// File: rtl/wdg_pulse.sv
module wdg_pulse #(
  parameter int unsigned PULSE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active,
  output logic done
);

  localparam int unsigned PW = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;

  logic          act_q;
  logic [PW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      left_q <= '0;
    end else if (!act_q) begin
      if (start) begin
        act_q  <= 1'b1;
        left_q <= PW'(PULSE_CYCLES - 1);
      end
    end else if (left_q == '0) begin
      act_q <= 1'b0;
    end else begin
      left_q <= left_q - PW'(1);
    end
  end

  assign active = act_q;
  assign done   = act_q && (left_q == '0);

endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
  import wdg_pkg::*;
#(
  parameter int unsigned       CNT_W        = 32,
  parameter logic [CNT_W-1:0]  COUNT_INIT   = '1,
  parameter logic [DATA_W-1:0] KEY_VALUE    = 32'h5AFE_C0DE,
  parameter int unsigned       PULSE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              wdg_rst_o
);

  logic             key_open;
  logic [CNT_W-1:0] cnt_val;
  wdg_en_t          en_val;
  logic             expire;
  logic             pulse_active;
  logic             pulse_done;
  logic             wr_ok;
  logic             wr_key;
  logic             wr_cnt;
  logic             wr_en;

  assign wr_ok  = reg_we && !pulse_active;
  assign wr_key = wr_ok && (reg_addr == ADDR_KEY);
  assign wr_cnt = wr_ok && key_open && (reg_addr == ADDR_CNT);
  assign wr_en  = wr_ok && key_open && (reg_addr == ADDR_EN);

  wdg_key_lock #(
    .KEY_W     (DATA_W),
    .KEY_VALUE (KEY_VALUE)
  ) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_key   (wr_key),
    .wdata    (reg_wdata),
    .clear    (pulse_done),
    .unlocked (key_open)
  );

  wdg_counter #(
    .CNT_W      (CNT_W),
    .COUNT_INIT (COUNT_INIT)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_cnt    (wr_cnt),
    .wr_en     (wr_en),
    .cnt_wdata (reg_wdata[CNT_W-1:0]),
    .en_wdata  (wdg_en_t'(reg_wdata[EN_W-1:0])),
    .freeze    (pulse_active),
    .clear     (pulse_done),
    .count     (cnt_val),
    .en        (en_val),
    .expire    (expire)
  );

  wdg_pulse #(
    .PULSE_CYCLES (PULSE_CYCLES)
  ) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (expire),
    .active (pulse_active),
    .done   (pulse_done)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_KEY: reg_rdata[0]          = key_open;
      ADDR_CNT: reg_rdata[CNT_W-1:0]  = cnt_val;
      ADDR_EN:  reg_rdata[EN_W-1:0]   = en_val;
      default:  reg_rdata             = '0;
    endcase
  end

  assign wdg_rst_o = pulse_active;

endmodule

// File: rtl/wdg_timer_chk.sv
module wdg_timer_chk
  import wdg_pkg::*;
#(
  parameter int unsigned       CNT_W        = 32,
  parameter logic [CNT_W-1:0]  COUNT_INIT   = '1,
  parameter logic [DATA_W-1:0] KEY_VALUE    = 32'h5AFE_C0DE,
  parameter int unsigned       PULSE_CYCLES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              wdg_rst_o,
  input logic              key_open,
  input logic [CNT_W-1:0]  cnt_val,
  input wdg_en_t           en_val
);

  localparam int unsigned RW = $clog2(PULSE_CYCLES + 2);

  logic [RW-1:0] run_q;
  logic          cnt_write;
  logic          fire_cond;

  assign cnt_write = reg_we && key_open && (reg_addr == ADDR_CNT);
  assign fire_cond = en_val.cnt_en && en_val.rst_en && (cnt_val == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else if (wdg_rst_o) run_q <= run_q + RW'(1);
    else run_q <= '0;
  end

  p_unlock_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADDR_KEY && !wdg_rst_o) |=>
      (key_open == ($past(reg_wdata) == KEY_VALUE)));

  p_locked_cnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADDR_CNT && !key_open && !en_val.cnt_en && !wdg_rst_o) |=>
      $stable(cnt_val));

  p_locked_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADDR_EN && !key_open && !wdg_rst_o) |=> $stable(en_val));

  p_decrement_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_val.cnt_en && cnt_val != '0 && !wdg_rst_o && !cnt_write) |=>
      (cnt_val == $past(cnt_val) - CNT_W'(1)));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_val.cnt_en && !wdg_rst_o && !cnt_write) |=> $stable(cnt_val));

  p_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_cond && !wdg_rst_o) |=> wdg_rst_o);

  p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wdg_rst_o && !fire_cond) |=> !wdg_rst_o);

  p_pulse_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdg_rst_o) |-> (run_q == RW'(PULSE_CYCLES)));

  p_after_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdg_rst_o) |-> (!key_open && en_val == '0 && cnt_val == COUNT_INIT));

endmodule

bind wdg_timer wdg_timer_chk #(
  .CNT_W        (CNT_W),
  .COUNT_INIT   (COUNT_INIT),
  .KEY_VALUE    (KEY_VALUE),
  .PULSE_CYCLES (PULSE_CYCLES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .wdg_rst_o (wdg_rst_o),
  .key_open  (key_open),
  .cnt_val   (cnt_val),
  .en_val    (en_val)
);

// File: tb/wdg_timer_tb.sv
`timescale 1ns/1ps
module wdg_timer_tb;

  localparam logic [31:0] KEY   = 32'h5AFE_C0DE;
  localparam logic [31:0] INIT  = 32'hFFFF_FFFF;
  localparam int          PULSE = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        wdg_rst_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  wdg_timer u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .wdg_rst_o (wdg_rst_o)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Counts negedges until the reset output rises, then the pulse width.
  task automatic wait_pulse(output int lat, output int width);
    lat = 0;
    while (!wdg_rst_o && lat < 100) begin
      @(negedge clk); lat++;
    end
    width = 0;
    while (wdg_rst_o && width < 100) begin
      width++; @(negedge clk);
    end
  endtask

  task automatic check_clean(input string req);
    logic [31:0] v;
    rd(2'd0, v); check(req, "key flag", v, 32'd0);
    rd(2'd1, v); check(req, "count", v, INIT);
    rd(2'd2, v); check(req, "enable", v, 32'd0);
    check(req, "reset out", {31'd0, wdg_rst_o}, 32'd0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] keys [6];
    int lat, width;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: reset state
    check_clean("R9");

    // R1: key sweep, exact value unlocks, others relock
    keys[0] = KEY;          keys[1] = KEY ^ 32'h1;
    keys[2] = KEY ^ 32'h8000_0000; keys[3] = 32'h0;
    keys[4] = 32'hFFFF_FFFF; keys[5] = KEY ^ 32'h0001_0000;
    for (int i = 0; i < 6; i++) begin
      wr(2'd0, KEY);
      wr(2'd0, keys[i]);
      rd(2'd0, v);
      check("R1", "key flag after key write", v, (keys[i] == KEY) ? 32'd1 : 32'd0);
    end

    // R2/R3: locked writes ignored
    wr(2'd0, KEY);
    wr(2'd2, 32'd0);
    wr(2'd1, 32'd50);
    wr(2'd0, 32'h1234_5678);
    wr(2'd1, 32'd7);
    rd(2'd1, v); check("R2", "count after locked write", v, 32'd50);
    wr(2'd2, 32'd3);
    rd(2'd2, v); check("R3", "enable after locked write", v, 32'd0);
    idle(5);
    check("R3", "no reset after locked enable", {31'd0, wdg_rst_o}, 32'd0);
    wr(2'd0, KEY);
    wr(2'd1, 32'd9);
    rd(2'd1, v); check("R2", "count after unlocked write", v, 32'd9);

    // R5: count-enable clear holds
    idle(12);
    rd(2'd1, v); check("R5", "count held", v, 32'd9);

    // R4: decrement by one per clock
    wr(2'd1, 32'd100);
    wr(2'd2, 32'd1);       // edge k: count-enable set, count still 100
    idle(10);              // ten decrements
    rd(2'd1, v); check("R4", "count after 10 clocks", v, 32'd90);
    rd(2'd2, v); check("R3", "enable readback", v, 32'd1);

    // R7: reset-enable clear, count stops at zero, no reset
    wr(2'd1, 32'd3);
    begin
      int hi;
      hi = 0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk); if (wdg_rst_o) hi++;
      end
      check("R7", "no reset without reset-enable", hi, 32'd0);
    end
    rd(2'd1, v); check("R7", "count parked at zero", v, 32'd0);
    wr(2'd2, 32'd3);
    wait_pulse(lat, width);
    check("R7", "latency after late reset-enable", lat, 32'd1);
    check("R8", "pulse width", width, PULSE);
    check_clean("R8");

    // R6/R8: sweep loaded count 0..15 with both enables set
    for (int n = 0; n < 16; n++) begin
      wr(2'd0, KEY);
      wr(2'd1, 32'd1000);
      wr(2'd2, 32'd3);
      wr(2'd1, n);
      wait_pulse(lat, width);
      check("R6", $sformatf("latency for count %0d", n), lat, n + 1);
      check("R8", $sformatf("width for count %0d", n), width, PULSE);
      rd(2'd0, v); check("R8", "relocked after pulse", v, 32'd0);
      rd(2'd1, v); check("R8", "count restored", v, INIT);
    end

    // R8: writes during the pulse are ignored
    wr(2'd0, KEY);
    wr(2'd2, 32'd3);
    wr(2'd1, 32'd0);
    @(negedge clk);        // pulse now high
    reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = KEY;
    @(negedge clk);
    reg_we = 1'b0;
    idle(PULSE + 1);
    check_clean("R8");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule